// File: doc/BRIEF.md
# Two-Channel Fuzzy Climate Controller

This block turns two 8-bit error codes, one for temperature and one for humidity, into three 8-bit actuator commands: warm, cool and dampen. Each code is graded against three fuzzy sets: below target, near target and above target. The near-target set is a triangle for temperature and a trapezoid for humidity. A pair of cheap consequent lines is applied to these degrees, 255 minus eight times the degree and the degree itself. Each command is the mean of the two rules that can fire for that input. The result is held in a register.

An error code comes from a signed measured-minus-target difference d as 4*d + 127. A helper function in the shared package performs this conversion for the logic that feeds the block. The code 127 therefore means "on target". Codes below 127 mean too cold or too dry, and codes above 127 mean too hot or too wet. The edges of the sloped set boundaries are parameters. All arithmetic uses unsigned integers.

Top module: `fz_climate_ctrl`

## Requirements
- R1: The package function `fz_err_code(d)` returns 4*d + 127 for a signed difference d in -30..30, so that -30 maps to 7, 0 to 127 and +30 to 247.
- R2: The temperature degrees, each 0..255, are defined with breakpoints LO=95 and HI=159 (defaults) and apex 127. below = 255 for code<=LO, floor((127-code)*255/(127-LO)) between them, and 0 for code>=127. near = 0 at or outside LO/HI, floor((code-LO)*255/(127-LO)) on the rising side, 255 at 127, and floor((HI-code)*255/(HI-127)) on the falling side. above mirrors below.
- R3: The humidity degrees use the same shape but with a flat top of 255 for codes 126..128 and default edges 94 and 160. below falls to 0 at 126, and above rises from 0 at 128.
- R4: For a degree x, the consequents are y1 = x and y0 = max(0, 255 - 8x). A near rule whose degree is 0 contributes 0.
- R5: warm = (y1(temp below) + g) >> 1, where g = y0(temp near) when the temperature code is below 127 and g = 0 otherwise.
- R6: cool = (y1(temp above) + g) >> 1, where g = y0(temp near) when the temperature code is above 127 and g = 0 otherwise.
- R7: dampen = (y1(hum below) + g) >> 1, where g = y0(hum near) when the humidity code is below 127 and g = 0 otherwise.
- R8: warm is 0 for every temperature code >= 127. cool is 0 for every temperature code <= 127. dampen is 0 for every humidity code >= 127.
- R9: A temperature code <= LO saturates warm at 127.
- R10: The outputs are registered. An input applied before a rising edge appears on the outputs after that edge, which gives one cycle of latency.
- R11: A synchronous active-high reset clears all three outputs to 0 at the next rising edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_code_i | input | 8 | Temperature error code |
| hum_code_i | input | 8 | Humidity error code |
| warm_o | output | 8 | Heater command |
| cool_o | output | 8 | Cooler command |
| damp_o | output | 8 | Humidifier command |

## Verification
Both codes are swept over all 256 values twice. In one pass they move together, and in the other they move in opposite directions. This shows that each command depends only on its own channel and never on the other code. The sweeps cross every breakpoint: the saturated tails, the 126/127/128 centre where the gating of the near rules switches, and the humidity flat top. This separates a mis-placed gate or a wrong slope from a correct one. A reset applied while nonzero commands are present, the conversion helper at its end points, and a check of when outputs change complete the tests of the registered behaviour.

// File: rtl/fz_pkg.sv
package fz_pkg;

    localparam int CODE_W = 8;
    localparam int DEG_W  = 8;

    typedef struct packed {
        logic [DEG_W-1:0] below;
        logic [DEG_W-1:0] near;
        logic [DEG_W-1:0] above;
    } fz_deg_t;

    typedef struct packed {
        logic [DEG_W-1:0] warm;
        logic [DEG_W-1:0] cool;
        logic [DEG_W-1:0] damp;
    } fz_cmd_t;

    // Map a signed measured-minus-target difference onto the 0..255 code space.
    function automatic logic [CODE_W-1:0] fz_err_code(input int diff);
        int v;
        v = diff * 4 + 127;
        return CODE_W'(v);
    endfunction

endpackage

// File: rtl/fz_member.sv
module fz_member #(
    parameter int CW      = 8,
    parameter int MW      = 8,
    parameter int LO      = 95,
    parameter int FLAT_LO = 127,
    parameter int FLAT_HI = 127,
    parameter int HI      = 159
) (
    input  logic [CW-1:0] code_i,
    output logic [MW-1:0] below_o,
    output logic [MW-1:0] near_o,
    output logic [MW-1:0] above_o
);
    localparam int MAXD   = (1 << MW) - 1;
    localparam int SPAN_L = FLAT_LO - LO;
    localparam int SPAN_R = HI - FLAT_HI;

    logic [31:0] c;
    logic [31:0] rise_l, fall_l, rise_r, fall_r;

    always_comb begin
        c      = 32'(code_i);
        rise_l = ((c - 32'(LO)) * 32'(MAXD)) / 32'(SPAN_L);
        fall_l = ((32'(FLAT_LO) - c) * 32'(MAXD)) / 32'(SPAN_L);
        rise_r = ((c - 32'(FLAT_HI)) * 32'(MAXD)) / 32'(SPAN_R);
        fall_r = ((32'(HI) - c) * 32'(MAXD)) / 32'(SPAN_R);

        if (c <= 32'(LO))           below_o = MW'(MAXD);
        else if (c >= 32'(FLAT_LO)) below_o = '0;
        else                        below_o = MW'(fall_l);

        if (c <= 32'(FLAT_HI))      above_o = '0;
        else if (c >= 32'(HI))      above_o = MW'(MAXD);
        else                        above_o = MW'(rise_r);

        if (c <= 32'(LO) || c >= 32'(HI)) near_o = '0;
        else if (c < 32'(FLAT_LO))        near_o = MW'(rise_l);
        else if (c <= 32'(FLAT_HI))       near_o = MW'(MAXD);
        else                              near_o = MW'(fall_r);
    end
endmodule

// File: rtl/fz_mean2.sv
module fz_mean2 #(
    parameter int MW = 8
) (
    input  logic [MW-1:0] lin_deg_i,
    input  logic [MW-1:0] near_deg_i,
    input  logic          near_en_i,
    output logic [MW-1:0] mean_o
);
    localparam int MAXD = (1 << MW) - 1;

    logic [MW+3:0] eight_x;
    logic [MW-1:0] y0;
    logic [MW-1:0] near_term;
    logic [MW:0]   sum;

    always_comb begin
        eight_x = {near_deg_i, 3'b000};
        if (eight_x > (MW+4)'(MAXD)) y0 = '0;
        else                         y0 = MW'((MW+4)'(MAXD) - eight_x);
        near_term = (near_en_i && near_deg_i != '0) ? y0 : '0;
        sum       = {1'b0, lin_deg_i} + {1'b0, near_term};
        mean_o    = sum[MW:1];
    end
endmodule

// File: rtl/fz_climate_ctrl.sv
module fz_climate_ctrl #(
    parameter int CW   = fz_pkg::CODE_W,
    parameter int MW   = fz_pkg::DEG_W,
    parameter int T_LO = 95,
    parameter int T_HI = 159,
    parameter int H_LO = 94,
    parameter int H_HI = 160
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] temp_code_i,
    input  logic [CW-1:0] hum_code_i,
    output logic [MW-1:0] warm_o,
    output logic [MW-1:0] cool_o,
    output logic [MW-1:0] damp_o
);
    localparam int MID = (1 << (CW - 1)) - 1;
    localparam int NCH = 3;

    logic [MW-1:0] t_below, t_near, t_above;
    logic [MW-1:0] h_below, h_near, h_above;

    fz_member #(.CW(CW), .MW(MW), .LO(T_LO), .FLAT_LO(MID), .FLAT_HI(MID), .HI(T_HI)) u_temp (
        .code_i (temp_code_i),
        .below_o(t_below),
        .near_o (t_near),
        .above_o(t_above)
    );

    fz_member #(.CW(CW), .MW(MW), .LO(H_LO), .FLAT_LO(MID - 1), .FLAT_HI(MID + 1), .HI(H_HI)) u_hum (
        .code_i (hum_code_i),
        .below_o(h_below),
        .near_o (h_near),
        .above_o(h_above)
    );

    logic [MW-1:0] lin_deg  [NCH];
    logic [MW-1:0] near_deg [NCH];
    logic          near_en  [NCH];
    logic [MW-1:0] mean_val [NCH];

    always_comb begin
        lin_deg[0]  = t_below;
        near_deg[0] = t_near;
        near_en[0]  = temp_code_i < CW'(MID);
        lin_deg[1]  = t_above;
        near_deg[1] = t_near;
        near_en[1]  = temp_code_i > CW'(MID);
        lin_deg[2]  = h_below;
        near_deg[2] = h_near;
        near_en[2]  = hum_code_i < CW'(MID);
    end

    for (genvar g = 0; g < NCH; g++) begin : g_out
        fz_mean2 #(.MW(MW)) u_mean (
            .lin_deg_i (lin_deg[g]),
            .near_deg_i(near_deg[g]),
            .near_en_i (near_en[g]),
            .mean_o    (mean_val[g])
        );
    end

    logic [MW-1:0] warm_d, cool_d, damp_d;
    logic [MW-1:0] warm_q, cool_q, damp_q;

    always_comb begin
        if (rst) begin
            warm_d = '0;
            cool_d = '0;
            damp_d = '0;
        end else begin
            warm_d = mean_val[0];
            cool_d = mean_val[1];
            damp_d = mean_val[2];
        end
    end

    always_ff @(posedge clk) begin
        warm_q <= warm_d;
        cool_q <= cool_d;
        damp_q <= damp_d;
    end

    assign warm_o = warm_q;
    assign cool_o = cool_q;
    assign damp_o = damp_q;
endmodule

// File: rtl/fz_climate_ctrl_chk.sv
module fz_climate_ctrl_chk #(
    parameter int CW   = 8,
    parameter int MW   = 8,
    parameter int T_LO = 95
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] temp_code_i,
    input logic [CW-1:0] hum_code_i,
    input logic [MW-1:0] warm_o,
    input logic [MW-1:0] cool_o,
    input logic [MW-1:0] damp_o
);
    localparam int MID = (1 << (CW - 1)) - 1;

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (warm_o == '0 && cool_o == '0 && damp_o == '0));

    p_warm_off_r8: assert property (@(posedge clk) disable iff (rst)
        (temp_code_i >= CW'(MID)) |=> (warm_o == '0));

    p_cool_off_r8: assert property (@(posedge clk) disable iff (rst)
        (temp_code_i <= CW'(MID)) |=> (cool_o == '0));

    p_damp_off_r8: assert property (@(posedge clk) disable iff (rst)
        (hum_code_i >= CW'(MID)) |=> (damp_o == '0));

    p_warm_sat_r9: assert property (@(posedge clk) disable iff (rst)
        (temp_code_i <= CW'(T_LO)) |=> (warm_o == MW'((1 << (MW - 1)) - 1)));
endmodule

bind fz_climate_ctrl fz_climate_ctrl_chk #(.CW(CW), .MW(MW), .T_LO(T_LO)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .temp_code_i(temp_code_i),
    .hum_code_i (hum_code_i),
    .warm_o     (warm_o),
    .cool_o     (cool_o),
    .damp_o     (damp_o)
);

// File: tb/fz_climate_ctrl_bench.sv
`timescale 1ns/1ps
module fz_climate_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] t_code = 8'd0;
    logic [7:0] h_code = 8'd0;
    logic [7:0] warm, cool, damp;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fz_climate_ctrl u_fz_climate_ctrl (
        .clk        (clk),
        .rst        (rst),
        .temp_code_i(t_code),
        .hum_code_i (h_code),
        .warm_o     (warm),
        .cool_o     (cool),
        .damp_o     (damp)
    );

    // Degree of one set for a code; kind 0 below, 1 near, 2 above.
    function automatic int ref_deg(int c, int lo, int flo, int fhi, int hi, int kind);
        if (kind == 0) begin
            if (c <= lo) return 255;
            if (c >= flo) return 0;
            return ((flo - c) * 255) / (flo - lo);
        end else if (kind == 2) begin
            if (c <= fhi) return 0;
            if (c >= hi) return 255;
            return ((c - fhi) * 255) / (hi - fhi);
        end
        if (c <= lo || c >= hi) return 0;
        if (c < flo) return ((c - lo) * 255) / (flo - lo);
        if (c <= fhi) return 255;
        return ((hi - c) * 255) / (hi - fhi);
    endfunction

    function automatic int ref_y0(int x);
        if (x == 0) return 0;
        if (8 * x > 255) return 0;
        return 255 - 8 * x;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_and_check(int tc, int hc);
        int tb_, tn, ta, hb, hn;
        int ew, ec, ed;
        @(negedge clk);
        t_code = 8'(tc);
        h_code = 8'(hc);
        @(posedge clk);
        @(negedge clk);
        tb_ = ref_deg(tc, 95, 127, 127, 159, 0);
        tn  = ref_deg(tc, 95, 127, 127, 159, 1);
        ta  = ref_deg(tc, 95, 127, 127, 159, 2);
        hb  = ref_deg(hc, 94, 126, 128, 160, 0);
        hn  = ref_deg(hc, 94, 126, 128, 160, 1);
        ew  = (tb_ + (tc < 127 ? ref_y0(tn) : 0)) / 2;
        ec  = (ta + (tc > 127 ? ref_y0(tn) : 0)) / 2;
        ed  = (hb + (hc < 127 ? ref_y0(hn) : 0)) / 2;
        check("R5 R2 R4 R10 warm", int'(warm), ew);
        check("R6 R2 R4 R10 cool", int'(cool), ec);
        check("R7 R3 R4 R10 dampen", int'(damp), ed);
        if (tc >= 127) check("R8 warm zero", int'(warm), 0);
        if (tc <= 127) check("R8 cool zero", int'(cool), 0);
        if (hc >= 127) check("R8 dampen zero", int'(damp), 0);
        if (tc <= 95) check("R9 warm saturation", int'(warm), 127);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: conversion helper
        check("R1 code(-30)", int'(fz_pkg::fz_err_code(-30)), 7);
        check("R1 code(0)", int'(fz_pkg::fz_err_code(0)), 127);
        check("R1 code(30)", int'(fz_pkg::fz_err_code(30)), 247);
        check("R1 code(-5)", int'(fz_pkg::fz_err_code(-5)), 107);

        rst = 1'b1;
        t_code = 8'd20;
        h_code = 8'd20;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 reset warm", int'(warm), 0);
        check("R11 reset cool", int'(cool), 0);
        check("R11 reset dampen", int'(damp), 0);
        rst = 1'b0;

        for (int i = 0; i < 256; i++) apply_and_check(i, i);
        for (int i = 0; i < 256; i++) apply_and_check(i, 255 - i);

        // R10: outputs hold until the next edge after an input change
        apply_and_check(20, 20);
        @(negedge clk);
        t_code = 8'd200;
        h_code = 8'd200;
        #1;
        check("R10 warm held before edge", int'(warm), 127);
        @(posedge clk);
        @(negedge clk);
        check("R10 warm after edge", int'(warm), 0);

        // R11: reset with nonzero outputs present
        apply_and_check(10, 10);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R11 mid-run warm", int'(warm), 0);
        check("R11 mid-run dampen", int'(damp), 0);
        rst = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule